// File: doc/BRIEF.md
# MSI Interrupt Remap Translator

This block sits on the path of message-signalled interrupt writes. Each write is a 64-bit address and a 32-bit data word. The block sends it on in one of three ways. It passes the write through untouched, it rebuilds it from an entry in the remap table, or it drops it with a fault code. A global enable turns remapping off entirely.

When the address is in the remappable format, the block forms a 16-bit table index, adding the subhandle from the data word when that option is selected. It asks an external fetcher for the entry and holds the request until the fetcher acknowledges. It then checks the data word and composes a new address and data from the returned fields. The two lowest address bits of the incoming write are kept. The fetcher itself checks that the entry is present and well formed, and it reports any problem through its fault input.

The block takes one request at a time. `req_ready` is low while a fetch is outstanding. Every accepted request yields exactly one single-cycle pulse, either on `out_valid` or on `flt_valid`.

Top module: `msi_remap_xlate`

## Requirements
- R1: With `remap_en` low, a 4-byte request is forwarded with address and data unchanged and `out_vec_mismatch` low. No fault is raised.
- R2: A request whose `req_bytes` is not 4 is dropped with `flt_code` 3 (size), whatever the other inputs are.
- R3: With remapping enabled, a nonzero address bits 63:32 drops the request with `flt_code` 1 (request reserved).
- R4: With remapping enabled and bits 63:32 zero, address bits 31:20 other than 0xFEE drop the request with `flt_code` 1.
- R5: A well-formed address with format bit 4 clear is forwarded unchanged, without a fetch.
- R6: With format bit 4 set, the index sent on `fet_index` is address bit 2 placed at bit 15, over address bits 19:5 in bits 14:0.
- R7: When address bit 3 (subhandle valid) is set, data bits 15:0 are added to that index modulo 2^16 before the fetch.
- R8: When subhandle valid is set and the fetch succeeds, nonzero data bits 31:16 drop the request with `flt_code` 1. A fault from the fetch takes precedence over this check.
- R9: When subhandle valid is clear, `out_vec_mismatch` is raised with the output if data bits 7:0 differ from the entry vector. Translation still completes.
- R10: The translated address has bits 63:32 zero, 0xFEE in 31:20, the destination in 19:12, zero in 11:4, the redirection hint in bit 3, the destination mode in bit 2, and the incoming address bits 1:0.
- R11: The translated data has the vector in 7:0, the delivery mode in 10:8, zero in 13:11, level bit 14 set to 1, the trigger mode in bit 15, and zero in 31:16.
- R12: A fetch acknowledged with `fet_fault` high drops the request with `flt_code` 2 (fetch).
- R13: A request that needs no fetch produces its result in the cycle after acceptance. A fetched request produces its result in the cycle after `fet_ack`. During the fetch, `req_ready` is low and `fet_req` and `fet_index` hold steady. There is never more than one result per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| remap_en | input | 1 | Global remapping enable |
| req_valid | input | 1 | Incoming write present |
| req_ready | output | 1 | Block can accept a write |
| req_addr | input | 64 | Incoming message address |
| req_data | input | 32 | Incoming message data |
| req_bytes | input | 3 | Access size in bytes |
| fet_req | output | 1 | Table entry request, held until acknowledged |
| fet_index | output | 16 | Table index to fetch |
| fet_ack | input | 1 | Fetcher has returned the entry |
| fet_fault | input | 1 | Fetch failed (entry absent or malformed) |
| fet_vector | input | 8 | Entry vector |
| fet_dlv | input | 3 | Entry delivery mode |
| fet_trig | input | 1 | Entry trigger mode |
| fet_dmode | input | 1 | Entry destination mode |
| fet_rh | input | 1 | Entry redirection hint |
| fet_dest | input | 8 | Entry destination |
| out_valid | output | 1 | Output write pulse |
| out_addr | output | 64 | Output message address |
| out_data | output | 32 | Output message data |
| out_vec_mismatch | output | 1 | Vector mismatch flag, valid with `out_valid` |
| flt_valid | output | 1 | Request dropped pulse |
| flt_code | output | 2 | Fault cause, valid with `flt_valid` |

## Verification
The assertions assume that the fetcher raises `fet_ack` only while `fet_req` is high, and that it raises it for a single cycle. The bench fetcher model acknowledges after a fixed delay and clears the acknowledge in the next cycle, so it stays within that assumption. The assertions also take the request fields to be meaningful only in the cycle a request is accepted. The bench therefore drives each request for exactly one accepting cycle and waits for its result before sending the next.

// File: rtl/msi_remap_xlate.sv
module msi_remap_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        remap_en,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  input  logic [31:0] req_data,
  input  logic [2:0]  req_bytes,
  output logic        fet_req,
  output logic [15:0] fet_index,
  input  logic        fet_ack,
  input  logic        fet_fault,
  input  logic [7:0]  fet_vector,
  input  logic [2:0]  fet_dlv,
  input  logic        fet_trig,
  input  logic        fet_dmode,
  input  logic        fet_rh,
  input  logic [7:0]  fet_dest,
  output logic        out_valid,
  output logic [63:0] out_addr,
  output logic [31:0] out_data,
  output logic        out_vec_mismatch,
  output logic        flt_valid,
  output logic [1:0]  flt_code
);
  localparam logic [11:0] HEAD      = 12'hFEE;
  localparam logic [1:0]  FLT_RSVD  = 2'd1;
  localparam logic [1:0]  FLT_FETCH = 2'd2;
  localparam logic [1:0]  FLT_SIZE  = 2'd3;

  typedef enum logic [1:0] {D_PASS, D_RSVD, D_SIZE, D_FETCH} dec_t;

  logic        busy;
  logic [15:0] idx_q;
  logic [7:0]  vec_q;
  logic        hi_nz_q;
  logic [1:0]  lo_q;
  logic        sub_q;
  logic        pass_q;

  logic        accept;
  logic [15:0] idx_base, idx_calc;
  dec_t        dec;

  assign accept    = req_valid && !busy;
  assign req_ready = !busy;
  assign fet_req   = busy;
  assign fet_index = idx_q;

  assign idx_base = {req_addr[2], req_addr[19:5]};
  assign idx_calc = idx_base + (req_addr[3] ? req_data[15:0] : 16'd0);

  always_comb begin
    if (req_bytes != 3'd4)                dec = D_SIZE;
    else if (!remap_en)                   dec = D_PASS;
    else if (req_addr[63:32] != 32'd0)    dec = D_RSVD;
    else if (req_addr[31:20] != HEAD)     dec = D_RSVD;
    else if (!req_addr[4])                dec = D_PASS;
    else                                  dec = D_FETCH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy             <= 1'b0;
      idx_q            <= '0;
      vec_q            <= '0;
      hi_nz_q          <= 1'b0;
      lo_q             <= '0;
      sub_q            <= 1'b0;
      pass_q           <= 1'b0;
      out_valid        <= 1'b0;
      out_addr         <= '0;
      out_data         <= '0;
      out_vec_mismatch <= 1'b0;
      flt_valid        <= 1'b0;
      flt_code         <= '0;
    end else begin
      out_valid <= 1'b0;
      flt_valid <= 1'b0;
      if (accept) begin
        case (dec)
          D_PASS: begin
            out_valid        <= 1'b1;
            out_addr         <= req_addr;
            out_data         <= req_data;
            out_vec_mismatch <= 1'b0;
            pass_q           <= 1'b1;
          end
          D_RSVD: begin
            flt_valid <= 1'b1;
            flt_code  <= FLT_RSVD;
          end
          D_SIZE: begin
            flt_valid <= 1'b1;
            flt_code  <= FLT_SIZE;
          end
          default: begin
            busy    <= 1'b1;
            idx_q   <= idx_calc;
            vec_q   <= req_data[7:0];
            hi_nz_q <= req_data[31:16] != 16'd0;
            lo_q    <= req_addr[1:0];
            sub_q   <= req_addr[3];
          end
        endcase
      end else if (busy && fet_ack) begin
        busy <= 1'b0;
        if (fet_fault) begin
          flt_valid <= 1'b1;
          flt_code  <= FLT_FETCH;
        end else if (sub_q && hi_nz_q) begin
          flt_valid <= 1'b1;
          flt_code  <= FLT_RSVD;
        end else begin
          out_valid        <= 1'b1;
          pass_q           <= 1'b0;
          out_addr         <= {32'd0, HEAD, fet_dest, 8'd0, fet_rh, fet_dmode, lo_q};
          out_data         <= {16'd0, fet_trig, 1'b1, 3'd0, fet_dlv, fet_vector};
          out_vec_mismatch <= !sub_q && (vec_q != fet_vector);
        end
      end
    end
  end

  p_one_result_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && flt_valid));

  p_fetch_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_req && !fet_ack) |=> (fet_req && $stable(fet_index) && !req_ready));

  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !remap_en && req_bytes == 3'd4)
      |=> (out_valid && out_addr == $past(req_addr) && out_data == $past(req_data)));

  p_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bytes != 3'd4)
      |=> (flt_valid && flt_code == FLT_SIZE && !out_valid));

  p_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && remap_en && req_bytes == 3'd4 && req_addr[63:32] != 32'd0)
      |=> (flt_valid && flt_code == FLT_RSVD));

  p_fetch_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_req && fet_ack && fet_fault) |=> (flt_valid && flt_code == FLT_FETCH));

  p_out_fmt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pass_q)
      |-> (out_addr[63:20] == {32'd0, HEAD} && out_data[14] && out_data[31:16] == 16'd0));
endmodule

// File: tb/sim_msi_remap_xlate.sv
module sim_msi_remap_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        remap_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [2:0]  req_bytes = 3'd4;
  logic        fet_req;
  logic [15:0] fet_index;
  logic        fet_ack = 1'b0;
  logic        fet_fault = 1'b0;
  logic [7:0]  fet_vector = '0;
  logic [2:0]  fet_dlv = '0;
  logic        fet_trig = 1'b0;
  logic        fet_dmode = 1'b0;
  logic        fet_rh = 1'b0;
  logic [7:0]  fet_dest = '0;
  logic        out_valid;
  logic [63:0] out_addr;
  logic [31:0] out_data;
  logic        out_vec_mismatch;
  logic        flt_valid;
  logic [1:0]  flt_code;

  always #5 clk = ~clk;

  msi_remap_xlate u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int n_fetch = 0;
  int fcnt = 0;
  int cyc = 0;
  logic [15:0] last_idx = '0;
  logic [15:0] bad_idx = 16'h7777;
  logic        hold_err = 1'b0;

  logic        g_out, g_flt, g_mism;
  logic [63:0] g_addr;
  logic [31:0] g_data;
  logic [1:0]  g_code;

  function automatic logic [7:0] m_vec(input logic [15:0] i); return i[7:0] ^ 8'h3C; endfunction
  function automatic logic [7:0] m_dest(input logic [15:0] i); return i[15:8] ^ 8'h11; endfunction

  function automatic logic [63:0] exp_addr(input logic [15:0] i, input logic [1:0] lo);
    return {32'd0, 12'hFEE, m_dest(i), 8'd0, i[2], i[1], lo};
  endfunction
  function automatic logic [31:0] exp_data(input logic [15:0] i);
    return {16'd0, i[0], 1'b1, 3'd0, i[10:8], m_vec(i)};
  endfunction
  function automatic logic [63:0] mk(input logic hi, input logic sub, input logic [14:0] lo15,
                                     input logic [1:0] lo2);
    return {32'd0, 12'hFEE, lo15, 1'b1, sub, hi, lo2};
  endfunction

  always @(negedge clk) begin
    if (fet_req && !req_ready) hold_err = hold_err; else if (fet_req) hold_err = 1'b1;
    if (fet_ack) begin
      fet_ack = 1'b0;
    end else if (fet_req) begin
      fcnt++;
      if (fcnt == 2) begin
        fcnt       = 0;
        last_idx   = fet_index;
        n_fetch++;
        fet_fault  = (fet_index == bad_idx);
        fet_vector = m_vec(fet_index);
        fet_dest   = m_dest(fet_index);
        fet_dlv    = fet_index[10:8];
        fet_trig   = fet_index[0];
        fet_dmode  = fet_index[1];
        fet_rh     = fet_index[2];
        fet_ack    = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic issue(input logic en, input logic [63:0] a, input logic [31:0] d,
                       input logic [2:0] b);
    int extra = 0;
    @(negedge clk);
    remap_en = en; req_addr = a; req_data = d; req_bytes = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    g_out = 0; g_flt = 0;
    for (int k = 0; k < 20; k++) begin
      if (out_valid || flt_valid) begin
        g_out = out_valid; g_flt = flt_valid; g_addr = out_addr; g_data = out_data;
        g_mism = out_vec_mismatch; g_code = flt_code;
        break;
      end
      @(negedge clk);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (out_valid || flt_valid) extra++;
    end
    chk("R13 single result", {62'd0, g_out, g_flt} == 64'd0 ? 64'd0 : 64'd1, 64'd1);
    chk("R13 no extra result", 64'(extra), 64'd0);
  endtask

  task automatic t_reset();
    chk("R13 reset ready", {63'd0, req_ready}, 64'd1);
    chk("R13 reset idle", {61'd0, out_valid, flt_valid, fet_req}, 64'd0);
  endtask

  task automatic t_disabled();
    issue(1'b0, 64'h1234_0000_ABCD_0003, 32'hDEAD_BEEF, 3'd4);
    chk("R1 out", {63'd0, g_out}, 64'd1);
    chk("R1 addr", g_addr, 64'h1234_0000_ABCD_0003);
    chk("R1 data", {32'd0, g_data}, 64'hDEAD_BEEF);
    chk("R1 mism", {63'd0, g_mism}, 64'd0);
  endtask

  task automatic t_size();
    issue(1'b1, mk(1'b0, 1'b0, 15'h0010, 2'b00), 32'h0, 3'd2);
    chk("R2 fault", {61'd0, g_out, g_flt, 1'b0} , 64'd2);
    chk("R2 code", {62'd0, g_code}, 64'd3);
    issue(1'b0, 64'h0, 32'h0, 3'd8);
    chk("R2 code disabled", {61'd0, g_flt, g_code}, 64'd7);
  endtask

  task automatic t_upper();
    issue(1'b1, 64'h0000_0001_FEE0_0010, 32'h0, 3'd4);
    chk("R3 fault", {61'd0, g_out, g_flt, 1'b0}, 64'd2);
    chk("R3 code", {62'd0, g_code}, 64'd1);
  endtask

  task automatic t_head();
    issue(1'b1, 64'h0000_0000_FED0_0010, 32'h0, 3'd4);
    chk("R4 fault", {61'd0, g_out, g_flt, 1'b0}, 64'd2);
    chk("R4 code", {62'd0, g_code}, 64'd1);
  endtask

  task automatic t_compat();
    int f0 = n_fetch;
    issue(1'b1, 64'h0000_0000_FEE1_200E, 32'h0000_4041, 3'd4);
    chk("R5 out", {63'd0, g_out}, 64'd1);
    chk("R5 addr", g_addr, 64'h0000_0000_FEE1_200E);
    chk("R5 data", {32'd0, g_data}, 64'h4041);
    chk("R5 no fetch", 64'(n_fetch - f0), 64'd0);
  endtask

  task automatic t_index();
    logic [15:0] i = 16'h9234;
    issue(1'b1, mk(1'b1, 1'b0, 15'h1234, 2'b10), {24'h0, m_vec(i)}, 3'd4);
    chk("R6 index", {48'd0, last_idx}, {48'd0, i});
    chk("R10 addr", g_addr, exp_addr(i, 2'b10));
    chk("R11 data", {32'd0, g_data}, {32'd0, exp_data(i)});
    chk("R9 match", {62'd0, g_out, g_mism}, 64'd2);
    chk("R13 ready during fetch", {63'd0, hold_err}, 64'd0);
  endtask

  task automatic t_mismatch();
    logic [15:0] i = 16'h0ABC;
    issue(1'b1, mk(1'b0, 1'b0, 15'h0ABC, 2'b01), {24'h0, m_vec(i) ^ 8'h01}, 3'd4);
    chk("R9 flagged", {62'd0, g_out, g_mism}, 64'd3);
    chk("R9 addr", g_addr, exp_addr(i, 2'b01));
    chk("R9 data", {32'd0, g_data}, {32'd0, exp_data(i)});
  endtask

  task automatic t_sub();
    issue(1'b1, mk(1'b0, 1'b1, 15'h0010, 2'b11), 32'h0000_0005, 3'd4);
    chk("R7 index add", {48'd0, last_idx}, 64'h0015);
    chk("R7 addr", g_addr, exp_addr(16'h0015, 2'b11));
    chk("R7 no mism", {62'd0, g_out, g_mism}, 64'd2);
    issue(1'b1, mk(1'b1, 1'b1, 15'h7FFF, 2'b00), 32'h0000_0002, 3'd4);
    chk("R7 index wrap", {48'd0, last_idx}, 64'h0001);
    chk("R11 wrap data", {32'd0, g_data}, {32'd0, exp_data(16'h0001)});
  endtask

  task automatic t_subrsvd();
    int f0 = n_fetch;
    issue(1'b1, mk(1'b0, 1'b1, 15'h0020, 2'b00), 32'h0001_0003, 3'd4);
    chk("R8 fetched", 64'(n_fetch - f0), 64'd1);
    chk("R8 fault", {61'd0, g_out, g_flt, 1'b0}, 64'd2);
    chk("R8 code", {62'd0, g_code}, 64'd1);
  endtask

  task automatic t_fetchfault();
    issue(1'b1, mk(1'b0, 1'b0, 15'h7777, 2'b00), 32'h0, 3'd4);
    chk("R12 fault", {61'd0, g_out, g_flt, 1'b0}, 64'd2);
    chk("R12 code", {62'd0, g_code}, 64'd2);
    issue(1'b1, mk(1'b0, 1'b1, 15'h7770, 2'b00), 32'h0100_0007, 3'd4);
    chk("R8 precedence R12 code", {61'd0, g_flt, g_code}, 64'd6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_size();
    t_upper();
    t_head();
    t_compat();
    t_index();
    t_mismatch();
    t_sub();
    t_subrsvd();
    t_fetchfault();
    finish_run();
  end
endmodule